// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block holds the character engines of one asynchronous serial channel. A parallel byte offered on the transmit handshake is turned into a frame on the serial output. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then one, one and a half or two high stop bits. Software can also hold the output low to send a line break.

The receiver watches the serial input. It confirms a start edge at mid-bit and drops a glitch that is not low there. It then samples every later bit at its centre and hands back one character per frame, with flags for parity error, framing error and break.

Both engines advance on a 16x oversampling enable. A divisor counter makes this enable from the system clock, and an optional divide-by-4 prescaler sits in front of the divisor. All frame settings come from one set of line-control inputs. The transmitter captures them when it accepts a byte. The receiver captures them when it detects a start edge.

Top module: `serial_framer`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A transmitted frame starts with a low start bit, followed by the data bits least significant bit first. The number of data bits is set by `cfg_wlen`: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Each bit lasts 16 ticks. The line is high while idle.
- R3: With `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 it makes the count of ones even, and with 1 it makes the count odd. The receiver applies the same rule and sets `rx_perr` on a mismatch.
- R4: The stop period is 16 ticks when `cfg_stop2`=0. When `cfg_stop2`=1 it is 24 ticks with 5-bit characters and 32 ticks with 6, 7 or 8-bit characters. `tx_ready` rises again at the end of the stop period.
- R5: One tick comes every `cfg_div` clock cycles, and a divisor of 0 counts as 1. With `cfg_pre4`=1 the tick comes every 4×`cfg_div` cycles.
- R6: A byte is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until the frame ends.
- R7: Each received frame gives one single-cycle `rx_valid` pulse. `rx_data` holds the data bits with the unused upper bits at zero.
- R8: A low on `rxd` that is high again at the 8th tick after detection is dropped and gives no character. A later valid frame is still received.
- R9: `rx_ferr` is set when the first stop bit samples low and the frame is not a break.
- R10: A frame that is low throughout, including the parity and stop positions, is reported once. It gives `rx_data`=0 with `rx_brk`=1 and with `rx_perr` and `rx_ferr` both 0. No further character is taken until the line has gone high.
- R11: `cfg_break`=1 drives `txd` low from the next clock edge. `txd` returns to the frame or idle level on the edge after `cfg_break` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Tick divisor (0 acts as 1) |
| cfg_pre4 | input | 1 | Extra divide-by-4 before the divisor |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_stop2 | input | 1 | Long stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the serial output low |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break detected for this character |

## Verification
`txd` is registered from the transmitter's next state, so it changes on the same edge that accepts a byte. With one tick per cycle, bit k of the frame then sits between edges 16k and 16k+16 after acceptance. The bench therefore samples each bit on the falling edge 8+16k cycles after the accept edge. It expects `tx_ready` on the falling edge just after edge 16×(1+bits+parity)+stop ticks, with one cycle of slack.

The `rx_valid` pulse comes about 8 ticks into the stop bit, after a two-flop synchroniser. Receive checks therefore wait for the captured strobe within a bounded window, instead of at one fixed cycle. `cfg_break` acts one edge after it is applied, and the bench checks it on the next falling edge. Frame-length checks at slower bit rates allow one tick of slack, because the divisor phase at acceptance is free-running.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } lcfg_t;

    // keep only the active data bits of a byte for a given length code
    function automatic logic [7:0] wmask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

endpackage

// File: rtl/sfr_baud.sv
module sfr_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             pre4,
    output logic             tick
);
    typedef struct packed {
        logic [1:0]       pre;
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t              s_d, s_q;
    logic             ena;
    logic [DIV_W-1:0] last;

    always_comb begin
        s_d   = s_q;
        ena   = !pre4 || (s_q.pre == 2'd3);
        s_d.pre = pre4 ? s_q.pre + 2'd1 : 2'd0;
        last  = (div == '0) ? '0 : div - 1'b1;
        tick  = ena && (s_q.cnt >= last);
        if (ena) begin
            s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
    import sfr_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  lcfg_t      cfg,
    input  logic       brk_req,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       txd
);
    localparam int CNT_W = $clog2(2 * OS);
    localparam logic [CNT_W-1:0] C_BIT = CNT_W'(OS - 1);
    localparam logic [CNT_W-1:0] C_S15 = CNT_W'(OS + OS / 2 - 1);
    localparam logic [CNT_W-1:0] C_S2  = CNT_W'(2 * OS - 1);

    typedef struct packed {
        phase_t           ph;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             pbit;
        logic [1:0]       wlen;
        logic             par_en;
        logic             stop2;
        logic             txd;
    } st_t;

    st_t              s_d, s_q;
    logic [2:0]       last_idx;
    logic [CNT_W-1:0] stop_end;
    logic [7:0]       masked;
    logic             bit_done;
    logic             line;

    always_comb begin
        s_d      = s_q;
        last_idx = 3'd4 + {1'b0, s_q.wlen};
        stop_end = !s_q.stop2 ? C_BIT : ((s_q.wlen == 2'd0) ? C_S15 : C_S2);
        bit_done = tick && (s_q.cnt == C_BIT);
        masked   = tx_data & wmask(cfg.wlen);
        case (s_q.ph)
            PH_IDLE: if (tx_valid) begin
                s_d.ph     = PH_START;
                s_d.cnt    = '0;
                s_d.idx    = '0;
                s_d.sh     = masked;
                s_d.pbit   = cfg.par_odd ^ (^masked);
                s_d.wlen   = cfg.wlen;
                s_d.par_en = cfg.par_en;
                s_d.stop2  = cfg.stop2;
            end
            PH_START: if (tick) begin
                if (bit_done) begin
                    s_d.cnt = '0;
                    s_d.ph  = PH_DATA;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_DATA: if (tick) begin
                if (bit_done) begin
                    s_d.cnt = '0;
                    s_d.sh  = s_q.sh >> 1;
                    if (s_q.idx == last_idx) s_d.ph = s_q.par_en ? PH_PAR : PH_STOP;
                    else                     s_d.idx = s_q.idx + 1'b1;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_PAR: if (tick) begin
                if (bit_done) begin
                    s_d.cnt = '0;
                    s_d.ph  = PH_STOP;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_STOP: if (tick) begin
                if (s_q.cnt == stop_end) s_d.ph = PH_IDLE;
                else                     s_d.cnt = s_q.cnt + 1'b1;
            end
            default: s_d.ph = PH_IDLE;
        endcase
        case (s_d.ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = s_d.sh[0];
            PH_PAR:   line = s_d.pbit;
            default:  line = 1'b1;
        endcase
        s_d.txd = line & ~brk_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ph  <= PH_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_ready = (s_q.ph == PH_IDLE);
    assign txd      = s_q.txd;

endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);
    localparam int CNT_W = $clog2(OS);
    localparam logic [CNT_W-1:0] C_MID = CNT_W'(OS / 2 - 1);
    localparam logic [CNT_W-1:0] C_BIT = CNT_W'(OS - 1);

    typedef struct packed {
        logic [1:0]       sync;
        phase_t           ph;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       data;
        logic             pbit;
        logic [1:0]       wlen;
        logic             par_en;
        logic             par_odd;
        logic             valid;
        logic [7:0]       o_data;
        logic             perr;
        logic             ferr;
        logic             brk;
    } st_t;

    st_t  s_d, s_q;
    logic line;
    logic bit_done;
    logic is_brk;

    always_comb begin
        s_d       = s_q;
        s_d.sync  = {s_q.sync[0], rxd};
        s_d.valid = 1'b0;
        line      = s_q.sync[1];
        bit_done  = tick && (s_q.cnt == C_BIT);
        is_brk    = !line && (s_q.data == 8'h00) && !(s_q.par_en && s_q.pbit);
        case (s_q.ph)
            PH_IDLE: if (tick && !line) begin
                s_d.ph      = PH_START;
                s_d.cnt     = '0;
                s_d.idx     = '0;
                s_d.data    = '0;
                s_d.pbit    = 1'b0;
                s_d.wlen    = wlen;
                s_d.par_en  = par_en;
                s_d.par_odd = par_odd;
            end
            PH_START: if (tick) begin
                if (s_q.cnt == C_MID) begin
                    s_d.cnt = '0;
                    s_d.ph  = line ? PH_IDLE : PH_DATA;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_DATA: if (tick) begin
                if (bit_done) begin
                    s_d.cnt            = '0;
                    s_d.data[s_q.idx]  = line;
                    if (s_q.idx == 3'd4 + {1'b0, s_q.wlen})
                        s_d.ph = s_q.par_en ? PH_PAR : PH_STOP;
                    else
                        s_d.idx = s_q.idx + 1'b1;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_PAR: if (tick) begin
                if (bit_done) begin
                    s_d.cnt  = '0;
                    s_d.pbit = line;
                    s_d.ph   = PH_STOP;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_STOP: if (tick) begin
                if (bit_done) begin
                    s_d.valid  = 1'b1;
                    s_d.o_data = s_q.data;
                    s_d.brk    = is_brk;
                    s_d.ferr   = !is_brk && !line;
                    s_d.perr   = !is_brk && s_q.par_en
                                 && ((^s_q.data) ^ s_q.pbit ^ s_q.par_odd);
                    s_d.ph     = line ? PH_IDLE : PH_HOLD;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            PH_HOLD: if (line) s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_valid = s_q.valid;
    assign rx_data  = s_q.o_data;
    assign rx_perr  = s_q.perr;
    assign rx_ferr  = s_q.ferr;
    assign rx_brk   = s_q.brk;

endmodule

// File: rtl/serial_framer.sv
module serial_framer
    import sfr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_pre4,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_stop2,
    input  logic             cfg_break,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_brk
);
    logic  tick;
    lcfg_t cfg;

    assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

    sfr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .pre4(cfg_pre4), .tick(tick)
    );

    sfr_tx #(.OS(OS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .brk_req(cfg_break),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd)
    );

    sfr_rx #(.OS(OS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wlen(cfg_wlen),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_break,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_brk
);
    // R6
    accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !cfg_break) |=> (!txd && !tx_ready));

    // R11
    break_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |=> !txd);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && $past(tx_ready) && !$past(cfg_break)) |-> txd);

    // R7
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    break_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == 8'h00 && !rx_perr && !rx_ferr));

    // R9
    ferr_not_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ferr) |-> !rx_brk);

endmodule

bind serial_framer sfr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_break(cfg_break), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
);

// File: tb/sim_serial_framer.sv
module sim_serial_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic        cfg_pre4 = 1'b0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_break = 1'b0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_ready, txd, rx_valid, rx_perr, rx_ferr, rx_brk;
    logic [7:0]  rx_data;
    logic        sel_loop = 1'b1;
    logic        line = 1'b1;
    logic        rxd;

    int checks = 0, fails = 0, cyc = 0, nvalid = 0;
    logic       got = 1'b0;
    logic [7:0] g_data;
    logic       g_perr, g_ferr, g_brk;

    assign rxd = sel_loop ? txd : line;

    always #10 clk = ~clk;

    serial_framer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_pre4(cfg_pre4),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_break(cfg_break), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    // {wlen[12:11], par_en[10], par_odd[9], stop2[8], data[7:0]}
    localparam logic [12:0] VEC [8] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd3, 1'b1, 1'b0, 1'b0, 8'hC3},
        {2'd3, 1'b1, 1'b1, 1'b1, 8'h01},
        {2'd0, 1'b0, 1'b0, 1'b1, 8'hFF},
        {2'd1, 1'b1, 1'b1, 1'b0, 8'h2A},
        {2'd2, 1'b0, 1'b0, 1'b1, 8'h7F},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'h13},
        {2'd3, 1'b0, 1'b0, 1'b1, 8'h80}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rx_valid) begin
            got    = 1'b1;
            g_data = rx_data;
            g_perr = rx_perr;
            g_ferr = rx_ferr;
            g_brk  = rx_brk;
            nvalid++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected finish");
            summary();
            $finish;
        end
    end

    task automatic wait_got(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (got) break;
        end
    endtask

    task automatic run_vec(input logic [12:0] v);
        int n, pe, stop_t, total, ready_at, pos;
        logic [7:0] md;
        logic par;
        cfg_wlen = v[12:11]; cfg_par_en = v[10]; cfg_par_odd = v[9]; cfg_stop2 = v[8];
        sel_loop = 1'b1;
        n      = 5 + int'(v[12:11]);
        pe     = int'(v[10]);
        md     = v[7:0] & (8'hFF >> (3 - n + 5));
        par    = v[9] ^ (^md);
        stop_t = !v[8] ? 16 : (n == 5 ? 24 : 32);
        total  = 16 * (1 + n + pe) + stop_t;
        ready_at = -1;
        got = 1'b0;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = v[7:0];
        @(posedge clk);
        for (int i = 1; i <= 700; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
            if (i == 8) begin
                chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
                chk(tx_ready == 1'b0, "R6 busy in frame", int'(tx_ready), 0);
            end
            if (i > 8 && (i - 8) % 16 == 0) begin
                pos = (i - 8) / 16;
                if (pos >= 1 && pos <= n)
                    chk(txd == md[pos-1], "R2 data bit", int'(txd), int'(md[pos-1]));
                else if (pos == n + 1 && pe == 1)
                    chk(txd == par, "R3 parity bit", int'(txd), int'(par));
                else if (pos == n + 1 + pe)
                    chk(txd == 1'b1, "R4 stop bit", int'(txd), 1);
            end
            if (tx_ready) begin
                ready_at = i;
                break;
            end
        end
        chk(ready_at >= total && ready_at <= total + 2, "R4 frame length", ready_at, total + 1);
        wait_got(60);
        chk(got == 1'b1, "R7 character received", int'(got), 1);
        chk(g_data == md, "R7 received data", int'(g_data), int'(md));
        chk(!g_perr && !g_ferr && !g_brk, "R3 no error flags",
            int'({g_perr, g_ferr, g_brk}), 0);
    endtask

    task automatic measure(input logic [15:0] d, input logic p4, input int per);
        int at, exp;
        cfg_div = d; cfg_pre4 = p4;
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        exp = 160 * per + 1;
        at = -1;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'h55;
        @(posedge clk);
        for (int i = 1; i <= 8000; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
            if (tx_ready) begin
                at = i;
                break;
            end
        end
        chk(at >= exp - per - 1 && at <= exp + per + 1, "R5 tick rate", at, exp);
        cfg_div = 16'd1; cfg_pre4 = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic drive(input logic [15:0] bits, input int n);
        sel_loop = 1'b0;
        for (int i = 0; i < n; i++) begin
            line = bits[i];
            repeat (16) @(negedge clk);
        end
        line = 1'b1;
    endtask

    initial begin
        int nv0;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        foreach (VEC[k]) begin
            run_vec(VEC[k]);
            repeat (20) @(negedge clk);
        end

        // R5: divisor, zero divisor, prescaler
        measure(16'd2, 1'b0, 2);
        measure(16'd0, 1'b0, 1);
        measure(16'd3, 1'b1, 12);

        // R3: parity error, 8 bits even, data 0x01 with parity 0
        cfg_wlen = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
        got = 1'b0;
        drive({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
        wait_got(40);
        chk(got && g_data == 8'h01 && g_perr && !g_ferr && !g_brk, "R3 parity error",
            int'({g_perr, g_ferr, g_brk}), 4);
        repeat (40) @(negedge clk);

        // R9: framing error, 8N1 data 0x5A, stop low
        cfg_par_en = 1'b0;
        got = 1'b0;
        drive({6'b0, 1'b0, 8'h5A, 1'b0}, 10);
        wait_got(40);
        chk(got && g_data == 8'h5A && g_ferr && !g_perr && !g_brk, "R9 framing error",
            int'({g_perr, g_ferr, g_brk}), 2);
        repeat (40) @(negedge clk);

        // R10: break, line low for 14 bit times
        got = 1'b0;
        nv0 = nvalid;
        drive(16'h0000, 14);
        repeat (100) @(negedge clk);
        chk(nvalid - nv0 == 1, "R10 one break character", nvalid - nv0, 1);
        chk(g_data == 8'h00 && g_brk && !g_ferr && !g_perr, "R10 break flags",
            int'({g_data, g_perr, g_ferr, g_brk}), 1);

        // R8: false start, low for 5 cycles
        nv0 = nvalid;
        sel_loop = 1'b0;
        line = 1'b0;
        repeat (5) @(negedge clk);
        line = 1'b1;
        repeat (300) @(negedge clk);
        chk(nvalid == nv0, "R8 glitch dropped", nvalid - nv0, 0);
        got = 1'b0;
        drive({6'b0, 1'b1, 8'h3C, 1'b0}, 10);
        wait_got(40);
        chk(got && g_data == 8'h3C && !g_ferr, "R8 next frame received", int'(g_data), 8'h3C);

        // R11: forced break on the output
        sel_loop = 1'b1;
        repeat (20) @(negedge clk);
        cfg_break = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R11 break drives low", int'(txd), 0);
        repeat (30) @(negedge clk);
        chk(txd == 1'b0 && tx_ready, "R11 break held", int'(txd), 0);
        cfg_break = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R11 release to idle", int'(txd), 1);
        repeat (300) @(negedge clk);

        summary();
        $finish;
    end

endmodule